// File: doc/BRIEF.md
# Key-Guarded Watchdog Reset Timer

This block is a watchdog counter for a system-control area. It counts up on a clock-enable tick toward a programmed limit. When the count reaches that limit, the block records a timeout event. If reset generation is armed, it also raises a sticky system reset request. The control state can only be changed through a two-step key handshake, so a runaway program cannot easily disarm or reprogram it. The guarded state is the limit, the arm/enable bits and the event flag.

A bus master first writes one 16-bit key to a first key register, then a second key to a second key register. The next bus write is then allowed to change one guarded register. That write uses up the unlock, and any further guarded write needs both keys again. The event flag can also be cleared through an unguarded interrupt-clear register. The live count value can be read back at any time.

Top module: `wdt_keyed_top`

## Requirements
- R1: After the synchronous reset (`rst` high), the event flag reads 0, the limit reads all ones, the control register reads 0 and the count reads 0. `irq` and `reset_req` are 0.
- R2: Register addresses are KEY1=0, KEY2=1, STAT=2, LIMIT=3, CTRL=4, COUNT=5, ICLR=6. Writing 0xBABA to KEY1 and then 0xEB10 to KEY2, in back-to-back bus writes, lets the next bus write to STAT, LIMIT or CTRL take effect.
- R3: The unlock is used up by the first bus write that follows it. A second guarded write without a fresh key pair leaves the register unchanged.
- R4: A guarded write with no valid unlock is ignored. The unlock returns to idle on a wrong key value, on a KEY2 write with no KEY1 before it, or on any other bus write between the two keys.
- R5: While CTRL bit 0 is 1, the count rises by one on each cycle with `cnt_tick` high. It holds while `cnt_tick` is low. It is forced to 0 while CTRL bit 0 is 0, and on every accepted LIMIT or CTRL write.
- R6: On a tick where the count equals the limit and CTRL bit 0 is 1, the count returns to 0 and the event flag (STAT bit 0) is set. `irq` follows the event flag.
- R7: If CTRL bit 1 is 1 on that matching tick, `reset_req` goes high and stays high until `rst`. Clearing the event flag does not drop it.
- R8: The event flag is cleared by an accepted STAT write with bit 0 equal to 0, or by an unguarded ICLR write with bit 0 equal to 1. A match in the same cycle wins over either clear.
- R9: Reads are registered. `bus_rdata` shows the addressed register one cycle after the address is presented. COUNT returns the live count.
- R10: With CTRL bit 1 equal to 0, a match sets the event flag but never raises `reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count enable strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | 1 | Timeout event flag |
| reset_req | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with an 8-bit counter and a 32-bit bus. This makes it cheap to sweep every limit from 0 to 15 and check that the event lands after exactly limit+1 ticks, with the count read back one tick earlier. With the short counter, every unlock abort path and the match-versus-clear collision can be reached within a few hundred cycles. The sticky reset request can then be exercised through to an external reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_KEY1  = 3'd0,
    A_KEY2  = 3'd1,
    A_STAT  = 3'd2,
    A_LIMIT = 3'd3,
    A_CTRL  = 3'd4,
    A_COUNT = 3'd5,
    A_ICLR  = 3'd6
  } wdt_addr_t;

  localparam logic [15:0] KEY_FIRST  = 16'hBABA;
  localparam logic [15:0] KEY_SECOND = 16'hEB10;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_HALF = 2'd1,
    UL_OPEN = 2'd2
  } ul_state_t;

  typedef struct packed {
    logic rst_en;
    logic cnt_en;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              grant,
  output logic              wr_stat,
  output logic              wr_limit,
  output logic              wr_ctrl
);
  ul_state_t state_q, state_d;
  logic      key1_ok, key2_ok;

  assign key1_ok = (bus_addr == A_KEY1) && (bus_wdata == DW'(KEY_FIRST));
  assign key2_ok = (bus_addr == A_KEY2) && (bus_wdata == DW'(KEY_SECOND));

  always_comb begin
    state_d = state_q;
    if (bus_wr) begin
      case (state_q)
        UL_IDLE: state_d = key1_ok ? UL_HALF : UL_IDLE;
        UL_HALF: state_d = key2_ok ? UL_OPEN : UL_IDLE;
        default: state_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= UL_IDLE;
    else     state_q <= state_d;
  end

  assign grant    = (state_q == UL_OPEN);
  assign wr_stat  = bus_wr && grant && (bus_addr == A_STAT);
  assign wr_limit = bus_wr && grant && (bus_addr == A_LIMIT);
  assign wr_ctrl  = bus_wr && grant && (bus_addr == A_CTRL);
endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_limit,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] bus_wdata,
  output logic [CW-1:0] limit_q,
  output wdt_ctrl_t     ctrl_q,
  output logic          cnt_clr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '1;
      ctrl_q  <= '0;
    end else begin
      if (wr_limit) limit_q <= bus_wdata[CW-1:0];
      if (wr_ctrl)  ctrl_q  <= wdt_ctrl_t'(bus_wdata[1:0]);
    end
  end

  assign cnt_clr = wr_limit || wr_ctrl;
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_tick,
  input  logic          cnt_en,
  input  logic          rst_en,
  input  logic          cnt_clr,
  input  logic          stat_clr,
  input  logic [CW-1:0] limit_q,
  output logic [CW-1:0] cnt_q,
  output logic          status_q,
  output logic          req_q
);
  logic hit;

  assign hit = cnt_en && cnt_tick && (cnt_q == limit_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      status_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      if (cnt_clr || !cnt_en)  cnt_q <= '0;
      else if (hit)            cnt_q <= '0;
      else if (cnt_tick)       cnt_q <= cnt_q + 1'b1;

      if (hit)                 status_q <= 1'b1;
      else if (stat_clr)       status_q <= 1'b0;

      if (hit && rst_en)       req_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic              reset_req
);
  logic          grant, wr_stat, wr_limit, wr_ctrl, cnt_clr;
  logic          stat_clr, status_q, req_q;
  logic [CW-1:0] limit_q, cnt_q;
  wdt_ctrl_t     ctrl_q;
  logic          ctrl_en, ctrl_rst_en;

  wdt_unlock #(.DW(DW)) u_unlock (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .grant(grant), .wr_stat(wr_stat),
    .wr_limit(wr_limit), .wr_ctrl(wr_ctrl)
  );

  wdt_cfg_regs #(.DW(DW), .CW(CW)) u_cfg (
    .clk(clk), .rst(rst), .wr_limit(wr_limit), .wr_ctrl(wr_ctrl),
    .bus_wdata(bus_wdata), .limit_q(limit_q), .ctrl_q(ctrl_q),
    .cnt_clr(cnt_clr)
  );

  assign ctrl_en     = ctrl_q.cnt_en;
  assign ctrl_rst_en = ctrl_q.rst_en;
  assign stat_clr    = (wr_stat && !bus_wdata[0]) ||
                       (bus_wr && (bus_addr == A_ICLR) && bus_wdata[0]);

  wdt_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .cnt_en(ctrl_en),
    .rst_en(ctrl_rst_en), .cnt_clr(cnt_clr), .stat_clr(stat_clr),
    .limit_q(limit_q), .cnt_q(cnt_q), .status_q(status_q), .req_q(req_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_STAT:  bus_rdata <= DW'(status_q);
        A_LIMIT: bus_rdata <= DW'(limit_q);
        A_CTRL:  bus_rdata <= DW'(ctrl_q);
        A_COUNT: bus_rdata <= DW'(cnt_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign irq       = status_q;
  assign reset_req = req_q;
endmodule

// File: rtl/wdt_keyed_sva.sv
module wdt_keyed_sva
  import wdt_pkg::*;
#(
  parameter int CW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_tick,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              grant,
  input logic [CW-1:0]     limit_q,
  input logic [CW-1:0]     cnt_q,
  input logic              ctrl_en,
  input logic              ctrl_rst_en,
  input logic              status_q,
  input logic              reset_req
);
  // R3: an open unlock never survives a bus write
  a_r3_single_use: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && grant) |=> !grant);

  // R4: without an unlock the limit and control bits stay put
  a_r4_limit_guarded: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !grant) |=> $stable(limit_q) && $stable(ctrl_en) && $stable(ctrl_rst_en));

  // R5: no tick and no write means the count holds
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!cnt_tick && !bus_wr) |=> $stable(cnt_q));

  // R6: the count never passes the limit
  a_r6_within_limit: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= limit_q);

  // R6: a matching tick sets the event flag
  a_r6_flag_on_match: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && ctrl_en && (cnt_q == limit_q)) |=> status_q);

  // R7: reset request is sticky
  a_r7_req_sticky: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> reset_req);

  // R10: reset request rises only when armed
  a_r10_req_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_req) |-> $past(ctrl_rst_en));
endmodule

bind wdt_keyed_top wdt_keyed_sva #(.CW(CW)) u_sva (
  .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .grant(grant), .limit_q(limit_q), .cnt_q(cnt_q),
  .ctrl_en(ctrl_en), .ctrl_rst_en(ctrl_rst_en), .status_q(status_q),
  .reset_req(reset_req)
);

// File: tb/tb_wdt_keyed_top.sv
module tb_wdt_keyed_top;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam logic [2:0] K1 = 3'd0, K2 = 3'd1, ST = 3'd2, LM = 3'd3,
                         CT = 3'd4, CN = 3'd5, IC = 3'd6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cnt_tick = 1'b0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq, reset_req;
  int            checks = 0;
  int            errors = 0;
  int            cycles = 0;

  always #2 clk = ~clk;

  wdt_keyed_top #(.DW(DW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .reset_req(reset_req)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic unlock();
    wr(K1, 32'hBABA);
    wr(K2, 32'hEB10);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_tick = 1'b1;
      @(negedge clk); cnt_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(ST, 0, "R1 stat");
    rd(LM, 32'hFF, "R1 limit");
    rd(CT, 0, "R1 ctrl");
    rd(CN, 0, "R1 count");
    chk("R1 irq", DW'(irq), 0);
    chk("R1 reset_req", DW'(reset_req), 0);

    // R4 aborts and unguarded writes
    wr(LM, 32'h11);
    rd(LM, 32'hFF, "R4 no unlock");
    wr(K1, 32'hBABB); wr(K2, 32'hEB10); wr(LM, 32'h12);
    rd(LM, 32'hFF, "R4 wrong key1");
    wr(K2, 32'hEB10); wr(LM, 32'h13);
    rd(LM, 32'hFF, "R4 key2 alone");
    wr(K1, 32'hBABA); wr(CN, 32'h0); wr(K2, 32'hEB10); wr(LM, 32'h14);
    rd(LM, 32'hFF, "R4 write between keys");
    wr(K1, 32'hBABA); wr(K2, 32'hEB11); wr(LM, 32'h15);
    rd(LM, 32'hFF, "R4 wrong key2");

    // R2 and R3
    unlock(); wr(LM, 32'h05);
    rd(LM, 32'h05, "R2 accepted");
    wr(LM, 32'h07);
    rd(LM, 32'h05, "R3 consumed");
    wr(CT, 32'h1);
    rd(CT, 0, "R3 ctrl consumed");

    // R5 R6 R8 R9 R10 sweep over limits
    for (int m = 0; m < 16; m++) begin
      unlock(); wr(ST, 0);
      rd(ST, 0, "R8 guarded clear");
      unlock(); wr(LM, DW'(m));
      unlock(); wr(CT, 32'h1);
      tick(m);
      rd(CN, DW'(m), "R9 count readback");
      rd(CN, DW'(m), "R5 hold without tick");
      rd(ST, 0, "R6 no early event");
      tick(1);
      rd(ST, 1, "R6 event at limit");
      chk("R6 irq", DW'(irq), 1);
      rd(CN, 0, "R6 count wraps");
      chk("R10 no reset_req", DW'(reset_req), 0);
    end

    // R4 unguarded status clear ignored
    wr(ST, 0);
    rd(ST, 1, "R4 stat guarded");
    // R8 ICLR clears
    wr(IC, 1);
    rd(ST, 0, "R8 iclr");

    // R5 disable zeroes count
    tick(3);
    rd(CN, 3, "R5 counting");
    unlock(); wr(CT, 0);
    tick(2);
    rd(CN, 0, "R5 disabled");

    // R8 match wins over clear
    unlock(); wr(LM, 2);
    unlock(); wr(CT, 1);
    tick(2);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = IC; bus_wdata = 1; cnt_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; cnt_tick = 1'b0;
    rd(ST, 1, "R8 match beats clear");

    // R7 armed reset
    unlock(); wr(LM, 3);
    unlock(); wr(CT, 3);
    tick(3);
    chk("R7 not yet", DW'(reset_req), 0);
    tick(1);
    chk("R7 reset_req", DW'(reset_req), 1);
    wr(IC, 1);
    rd(ST, 0, "R7 flag cleared");
    chk("R7 sticky", DW'(reset_req), 1);
    tick(5);
    chk("R7 still held", DW'(reset_req), 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset drops req", DW'(reset_req), 0);
    rd(CT, 0, "R1 ctrl after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule